// File: doc/BRIEF.md
# Nested Fault Escalation Unit

This unit sits in the trap path of a small processor core. Each fault request is compared with the fault whose delivery is still in progress. The unit then does one of three things: it forwards the new fault unchanged, it replaces the pair with a double fault (vector 8, error code zero), or it asks for a machine shutdown when a hardware fault arrives while a double fault is being delivered.

A register holds the vector of the fault now in delivery, with 0 meaning none. The core pulses a delivery-done input when the handler entry is complete, and that pulse clears the register.

Software interrupts bypass the classification. A separate strobe reports misaligned accesses from alignment-checked vector operations as a general-protection fault. Every result is registered and appears one cycle after its request.

Top module: `fault_esc_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid_o`, `shutdown_o`, `out_vec_o` and `out_err_o` are all zero, and the held fault is 0 (none).
- R2: A request in cycle N gives exactly one of `out_valid_o` or `shutdown_o` high in cycle N+1, for one cycle only. Both stay low when no request is made.
- R3: Vectors 0, 10, 11, 12 and 13 are contributory, and a held value of 0 also counts as contributory. A contributory new hardware fault that meets a contributory held fault leaves as vector 8 with error code 0.
- R4: If the held fault is 14 and the new hardware fault is contributory or 14, the output is vector 8 with error code 0.
- R5: If the held fault is 8, a new hardware fault raises `shutdown_o` for one cycle and no vector is delivered. The held fault is left unchanged.
- R6: Every other combination of a hardware fault delivers the new vector and error code unchanged. This includes a benign fault that follows a held 14.
- R7: After a delivery, the held fault takes the outgoing vector only if that vector is contributory, 14 or 8. Any other outgoing vector leaves the held fault as it was.
- R8: A request with `flt_swint_i` high is delivered with its own vector and error code. It is never escalated or shut down, and it does not change the held fault.
- R9: `align_fault_i` without `flt_valid_i` is a hardware fault with vector 13 and error code 0. When both are high, the `flt_valid_i` request is used.
- R10: `deliver_done_i` clears the held fault to 0. A request in the same cycle is judged against the value held before the clear, and if that request updates the held fault, the update takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid_i | input | 1 | Fault request strobe |
| flt_vec_i | input | 8 | Requested vector |
| flt_err_i | input | 32 | Requested error code |
| flt_swint_i | input | 1 | Request is a software interrupt |
| align_fault_i | input | 1 | Misaligned-access fault strobe |
| deliver_done_i | input | 1 | Delivery of the held fault has completed |
| out_valid_o | output | 1 | Delivered vector strobe |
| out_vec_o | output | 8 | Final vector |
| out_err_o | output | 32 | Final error code |
| shutdown_o | output | 1 | One-cycle shutdown/reset request |

## Verification
The assertions check on every cycle that the output strobes are mutually exclusive and follow each request by exactly one cycle. They also check that a held 8 forces a shutdown, that a page fault on a held page fault leaves as vector 8 with error code 0, and that software interrupts never change the held fault.

Only the bench scenarios show the full pairing table and the values the held register actually reaches. They run every vector from 0 to 31, both as hardware fault and as software interrupt, against each reachable held state. After each case a follow-up fault exposes the held value. The bench scenarios also cover the clear on delivery-done that lands in the same cycle as a request, and the priority of the alignment strobe.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
    parameter int VEC_W = 8;
    parameter int ERR_W = 32;

    localparam logic [VEC_W-1:0] VEC_NONE = '0;
    localparam logic [VEC_W-1:0] VEC_DBL  = VEC_W'(8);
    localparam logic [VEC_W-1:0] VEC_GP   = VEC_W'(13);
    localparam logic [VEC_W-1:0] VEC_PG   = VEC_W'(14);
    localparam logic [VEC_W-1:0] VEC_CONTRIB_LO = VEC_W'(10);
    localparam logic [VEC_W-1:0] VEC_CONTRIB_HI = VEC_W'(13);

    typedef enum logic [1:0] {
        CLS_BENIGN,
        CLS_CONTRIB,
        CLS_PAGE,
        CLS_DOUBLE
    } fclass_e;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_DELIVER,
        ACT_SHUTDOWN
    } action_e;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [ERR_W-1:0] err;
        logic             swint;
    } fault_req_t;

    typedef struct packed {
        action_e          act;
        logic [VEC_W-1:0] vec;
        logic [ERR_W-1:0] err;
        logic             upd;
    } decision_t;

    function automatic fclass_e class_of(input logic [VEC_W-1:0] v);
        if (v == VEC_NONE || (v >= VEC_CONTRIB_LO && v <= VEC_CONTRIB_HI))
            return CLS_CONTRIB;
        else if (v == VEC_PG)
            return CLS_PAGE;
        else if (v == VEC_DBL)
            return CLS_DOUBLE;
        else
            return CLS_BENIGN;
    endfunction
endpackage

// File: rtl/fault_src_mux.sv
module fault_src_mux
    import fault_esc_pkg::*;
(
    input  logic             flt_valid_i,
    input  logic [VEC_W-1:0] flt_vec_i,
    input  logic [ERR_W-1:0] flt_err_i,
    input  logic             flt_swint_i,
    input  logic             align_fault_i,
    output logic             req_valid_o,
    output fault_req_t       req_o
);
    always_comb begin
        req_valid_o = flt_valid_i | align_fault_i;
        if (flt_valid_i) begin
            req_o.vec   = flt_vec_i;
            req_o.err   = flt_err_i;
            req_o.swint = flt_swint_i;
        end else begin
            req_o.vec   = VEC_GP;
            req_o.err   = '0;
            req_o.swint = 1'b0;
        end
    end
endmodule

// File: rtl/fault_class_eval.sv
module fault_class_eval
    import fault_esc_pkg::*;
(
    input  logic             req_valid_i,
    input  fault_req_t       req_i,
    input  logic [VEC_W-1:0] held_vec_i,
    output decision_t        dec_o
);
    fclass_e old_cls;
    fclass_e new_cls;
    logic    escalate;

    always_comb begin
        old_cls  = class_of(held_vec_i);
        new_cls  = class_of(req_i.vec);
        escalate = (old_cls == CLS_CONTRIB && new_cls == CLS_CONTRIB) ||
                   (old_cls == CLS_PAGE &&
                    (new_cls == CLS_CONTRIB || new_cls == CLS_PAGE));

        dec_o.act = ACT_IDLE;
        dec_o.vec = req_i.vec;
        dec_o.err = req_i.err;
        dec_o.upd = 1'b0;

        if (req_valid_i) begin
            if (req_i.swint) begin
                dec_o.act = ACT_DELIVER;
            end else if (old_cls == CLS_DOUBLE) begin
                dec_o.act = ACT_SHUTDOWN;
            end else begin
                dec_o.act = ACT_DELIVER;
                if (escalate) begin
                    dec_o.vec = VEC_DBL;
                    dec_o.err = '0;
                    dec_o.upd = 1'b1;
                end else begin
                    dec_o.upd = (new_cls != CLS_BENIGN);
                end
            end
        end
    end
endmodule

// File: rtl/fault_esc_unit.sv
module fault_esc_unit
    import fault_esc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flt_valid_i,
    input  logic [VEC_W-1:0] flt_vec_i,
    input  logic [ERR_W-1:0] flt_err_i,
    input  logic             flt_swint_i,
    input  logic             align_fault_i,
    input  logic             deliver_done_i,
    output logic             out_valid_o,
    output logic [VEC_W-1:0] out_vec_o,
    output logic [ERR_W-1:0] out_err_o,
    output logic             shutdown_o
);
    logic             req_valid;
    fault_req_t       req;
    decision_t        dec;
    logic [VEC_W-1:0] held_q;

    fault_src_mux u_src (
        .flt_valid_i   (flt_valid_i),
        .flt_vec_i     (flt_vec_i),
        .flt_err_i     (flt_err_i),
        .flt_swint_i   (flt_swint_i),
        .align_fault_i (align_fault_i),
        .req_valid_o   (req_valid),
        .req_o         (req)
    );

    fault_class_eval u_eval (
        .req_valid_i (req_valid),
        .req_i       (req),
        .held_vec_i  (held_q),
        .dec_o       (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= VEC_NONE;
            out_valid_o <= 1'b0;
            shutdown_o  <= 1'b0;
            out_vec_o   <= '0;
            out_err_o   <= '0;
        end else begin
            out_valid_o <= (dec.act == ACT_DELIVER);
            shutdown_o  <= (dec.act == ACT_SHUTDOWN);
            if (dec.act == ACT_DELIVER) begin
                out_vec_o <= dec.vec;
                out_err_o <= dec.err;
            end
            if (dec.upd)
                held_q <= dec.vec;
            else if (deliver_done_i)
                held_q <= VEC_NONE;
        end
    end

    // R2
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid_o && shutdown_o));

    // R2
    req_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i || align_fault_i) |=> (out_valid_o || shutdown_o));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(flt_valid_i || align_fault_i) |=> !(out_valid_o || shutdown_o));

    // R5
    triple_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i && !flt_swint_i && held_q == VEC_DBL) |=> shutdown_o);

    // R4
    page_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i && !flt_swint_i && held_q == VEC_PG && flt_vec_i == VEC_PG)
        |=> (out_valid_o && out_vec_o == VEC_DBL && out_err_o == '0));

    // R8
    swint_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i && flt_swint_i && !deliver_done_i) |=> (held_q == $past(held_q)));

    // R8
    swint_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid_i && flt_swint_i) |=> (out_valid_o && out_vec_o == $past(flt_vec_i)
                                          && out_err_o == $past(flt_err_i)));
endmodule

// File: tb/fault_esc_unit_tb.sv
module fault_esc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        flt_valid_i, flt_swint_i, align_fault_i, deliver_done_i;
    logic [7:0]  flt_vec_i;
    logic [31:0] flt_err_i;
    logic        out_valid_o, shutdown_o;
    logic [7:0]  out_vec_o;
    logic [31:0] out_err_o;

    int total = 0;
    int bad   = 0;
    logic [7:0] mem_m;

    always #10 clk = ~clk;

    fault_esc_unit u_dut (
        .clk(clk), .rst(rst),
        .flt_valid_i(flt_valid_i), .flt_vec_i(flt_vec_i), .flt_err_i(flt_err_i),
        .flt_swint_i(flt_swint_i), .align_fault_i(align_fault_i),
        .deliver_done_i(deliver_done_i),
        .out_valid_o(out_valid_o), .out_vec_o(out_vec_o), .out_err_o(out_err_o),
        .shutdown_o(shutdown_o)
    );

    function automatic logic contrib(input logic [7:0] v);
        return (v == 8'd0) || (v >= 8'd10 && v <= 8'd13);
    endfunction

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        flt_valid_i = 0; flt_swint_i = 0; align_fault_i = 0; deliver_done_i = 0;
        flt_vec_i = '0; flt_err_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mem_m = 8'd0;
    endtask

    // Drives one cycle of stimulus, then checks the registered result.
    task automatic step(input logic v, input logic [7:0] vec, input logic [31:0] err,
                        input logic sw, input logic al, input logic dn, input string tag);
        logic hv, usw, ov, sh, upd, esc;
        logic [7:0] uv, ev, nm;
        logic [31:0] ue, ee;
        hv = v | al;
        uv = v ? vec : 8'd13;
        ue = v ? err : 32'd0;
        usw = v ? sw : 1'b0;
        ov = 0; sh = 0; upd = 0; ev = uv; ee = ue; nm = mem_m;
        if (hv) begin
            if (usw) ov = 1;
            else if (mem_m == 8'd8) sh = 1;
            else begin
                ov = 1;
                esc = (contrib(mem_m) && contrib(uv)) ||
                      (mem_m == 8'd14 && (contrib(uv) || uv == 8'd14));
                if (esc) begin ev = 8'd8; ee = 32'd0; end
                if (contrib(ev) || ev == 8'd14 || ev == 8'd8) begin nm = ev; upd = 1; end
            end
        end
        if (!upd && dn) nm = 8'd0;

        @(negedge clk);
        flt_valid_i = v; flt_vec_i = vec; flt_err_i = err; flt_swint_i = sw;
        align_fault_i = al; deliver_done_i = dn;
        @(negedge clk);
        flt_valid_i = 0; align_fault_i = 0; deliver_done_i = 0; flt_swint_i = 0;
        total++;
        if (out_valid_o !== ov || shutdown_o !== sh ||
            (ov && (out_vec_o !== ev || out_err_o !== ee))) begin
            bad++;
            $display("FAIL %s: got valid=%0b shut=%0b vec=%0d err=%h, expected valid=%0b shut=%0b vec=%0d err=%h",
                     tag, out_valid_o, shutdown_o, out_vec_o, out_err_o, ov, sh, ev, ee);
        end
        mem_m = nm;
    endtask

    initial begin
        rst = 1'b1;
        do_reset();
        // R1: reset state at the ports
        total++;
        if (out_valid_o !== 0 || shutdown_o !== 0 || out_vec_o !== 0 || out_err_o !== 0) begin
            bad++;
            $display("FAIL R1: got valid=%0b shut=%0b vec=%0d err=%h, expected all zero",
                     out_valid_o, shutdown_o, out_vec_o, out_err_o);
        end
        // R2: no request, no strobe
        step(0, 8'd5, 32'h1, 0, 0, 0, "R2");
        // R1: held fault is none -> page fault passes
        step(1, 8'd14, 32'h77, 0, 0, 0, "R1");

        // Sweep: held state none / page / double, vectors 0..31, hw and sw
        for (int p = 0; p < 3; p++) begin
            for (int nv = 0; nv < 32; nv++) begin
                for (int s = 0; s < 2; s++) begin
                    string tg;
                    do_reset();
                    if (p >= 1) step(1, 8'd14, 32'h10, 0, 0, 0, "R6");
                    if (p == 2) step(1, 8'd14, 32'h20, 0, 0, 0, "R4");
                    if (s == 1) tg = "R8";
                    else if (p == 2) tg = "R5";
                    else if (contrib(8'(nv)) || (p == 1 && nv == 14)) tg = (p == 1) ? "R4" : "R3";
                    else tg = "R6";
                    step(1, 8'(nv), 32'hA500_0000 | 32'(nv * 3 + s), s[0], 0, 0, tg);
                    // R7: follow-up fault exposes the held value
                    step(1, 8'd14, 32'h5A, 0, 0, 0, "R7");
                end
            end
        end

        // R9: alignment strobe alone, and priority of explicit request
        do_reset();
        step(0, 8'd0, 32'h0, 0, 1, 0, "R9");
        do_reset();
        step(1, 8'd14, 32'h3, 0, 0, 0, "R9");
        do_reset();
        step(1, 8'd3, 32'hBEEF, 0, 1, 0, "R9");

        // R10: done clears the held page fault
        do_reset();
        step(1, 8'd14, 32'h1, 0, 0, 0, "R10");
        step(0, 8'd0, 32'h0, 0, 0, 1, "R10");
        step(1, 8'd14, 32'h2, 0, 0, 0, "R10");
        // R10: coincident done and fault use pre-clear value; update wins
        do_reset();
        step(1, 8'd14, 32'h1, 0, 0, 0, "R10");
        step(1, 8'd14, 32'h9, 0, 0, 1, "R10");
        step(1, 8'd3, 32'h4, 0, 0, 0, "R10");
        // R10: coincident done with a benign fault clears
        do_reset();
        step(1, 8'd14, 32'h1, 0, 0, 0, "R10");
        step(1, 8'd6, 32'h6, 0, 0, 1, "R10");
        step(1, 8'd14, 32'h7, 0, 0, 0, "R10");
        // R5: held double after shutdown stays, reset clears it (R1)
        do_reset();
        step(1, 8'd0, 32'h1, 0, 0, 0, "R3");
        step(1, 8'd3, 32'h1, 0, 0, 0, "R5");
        step(1, 8'd3, 32'h1, 0, 0, 0, "R5");
        do_reset();
        step(1, 8'd13, 32'h1, 0, 0, 0, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule